// File: doc/BRIEF.md
# Preset and Coincidence Controller

This block sits beside a 24-bit up/down pulse counter. It decides when the counter is loaded, and it reports how the running count stands against a target value. It compares the count with the target every cycle. It keeps a sticky coincidence flag that the host clears. It drives an external coincidence pin through an enable.

A load can come from three sources: the host preset command, a leading edge on the external preset input, and coincidence while ring mode is on. Each source is a level: the host command itself, the latched external-detect flag, or the latched coincidence flag. The three levels are ORed together. A load strobe is issued only when that OR goes from low to high. The external-detect flag holds the OR high, so once an external preset has been seen, no later preset from either the host or the external input is possible until the host clears the flag. In ring mode the counter is reloaded automatically each time it reaches the target, which suits cyclic feeds.

The strobe comes with the preset value that was captured at the moment the OR rose. The counter takes its new value from that pair.

Top module: `preset_coin_ctrl`

## Requirements
- R1: `cmp_gt`, `cmp_eq` and `cmp_lt` are level outputs, valid in the same cycle, and show count > target, count == target and count < target as unsigned numbers. Exactly one of them is high.
- R2: When count equals target at a clock edge, `coin_flag` is high after that edge. It stays high until it is cleared. If a clear arrives in the same cycle as equality, the set wins.
- R3: `coin_flag` falls at the clock edge where `coin_clr` is high and count differs from target.
- R4: `coin_pin` is high exactly when `coin_pin_en` is high and `coin_flag` is high.
- R5: When `host_preset` rises while no other source is active, `load_stb` is high for exactly one cycle after the next clock edge. `load_value` then holds the `preset_val` that was sampled at that edge.
- R6: A preset fires only when the OR of the three sources goes from low to high. While any source is held high, a rising edge on another source gives no strobe.
- R7: A low-to-high change of `ext_preset`, seen between two clock edges, sets `ext_flag` at the second edge. That first detection produces a load strobe one clock later.
- R8: While `ext_flag` is set, neither `host_preset` nor a new edge on `ext_preset` produces a load strobe.
- R9: `ext_clr` clears `ext_flag` at the next edge even while `ext_preset` is still high. A level held high does not set the flag again; only a new low-to-high change does.
- R10: With `ring_en` high and no other source active, `load_stb` is high two clock edges after the edge where count first equals target. With `ring_en` low, coincidence gives no strobe.
- R11: During and right after reset, `load_stb`, `ext_flag` and `coin_flag` are low. With count and target both 0, `coin_flag` is set after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | 24 | Current counter value |
| set_val | input | 24 | Target value for comparison |
| preset_val | input | 24 | Value to load into the counter |
| host_preset | input | 1 | Host preset command (level) |
| ext_preset | input | 1 | External preset input, already synchronised |
| ring_en | input | 1 | Automatic reload on coincidence |
| coin_clr | input | 1 | Host clear for the coincidence flag |
| ext_clr | input | 1 | Host clear for the external-detect flag |
| coin_pin_en | input | 1 | Enable for the external coincidence pin |
| load_stb | output | 1 | One-cycle counter load strobe |
| load_value | output | 24 | Value that goes with the load strobe |
| cmp_gt | output | 1 | Count above target |
| cmp_eq | output | 1 | Count equal to target |
| cmp_lt | output | 1 | Count below target |
| coin_flag | output | 1 | Latched coincidence |
| ext_flag | output | 1 | Latched external preset detection |
| coin_pin | output | 1 | External coincidence output |

## Verification
The assertions check these rules on every cycle:
- exactly one compare flag is high;
- the coincidence and external-detect flags hold, set and clear as required;
- the strobe never lasts more than one cycle;
- no load is issued while the external-detect flag has been high for the last two edges;
- the ring reload lands exactly two edges after coincidence.

Other behaviour depends on the order of stimulus across several cycles, and only the bench scenarios can show it:
- a second source is masked while another is held;
- the detect flag is cleared while the pin stays high;
- the captured preset value is the one that goes with the strobe;
- the flag comes up after reset with a zero count.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // Relation of count to target; exactly one member is high.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // State of the external preset detector.
    typedef struct packed {
        logic prev;   // ext_preset level seen at the last edge
        logic det;    // latched detection
    } ext_st_t;

endpackage

// File: rtl/pcc_compare.sv
module pcc_compare #(
    parameter int W = 24
) (
    input  logic [W-1:0]  count,
    input  logic [W-1:0]  target,
    output pcc_pkg::rel_t rel
);
    // Unsigned magnitude compare. The result is used in the same cycle.
    always_comb begin
        rel.eq = (count == target);
        rel.gt = (count >  target);
        rel.lt = !rel.eq && !rel.gt;
    end
endmodule

// File: rtl/pcc_coin_latch.sv
module pcc_coin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic eq,
    input  logic clr,
    output logic coin
);
    logic coin_d, coin_q;

    // Equality sets the flag, and it wins over a clear in the same cycle.
    always_comb begin
        coin_d = eq | (coin_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) coin_q <= 1'b0;
        else        coin_q <= coin_d;
    end

    assign coin = coin_q;

    // R2: a set flag with no clear stays set.
    a_r2_coin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (coin && !clr) |=> coin);

    // R3: a clear without equality drops the flag.
    a_r3_coin_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !eq) |=> !coin);
endmodule

// File: rtl/pcc_ext_latch.sv
module pcc_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic clr,
    output logic det
);
    import pcc_pkg::*;

    ext_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        rise      = ext_in & ~st_q.prev;
        st_d.prev = ext_in;
        // A new edge is never lost: it wins over a clear in the same cycle.
        st_d.det  = rise | (st_q.det & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det = st_q.det;

    // R7: a low-to-high change of the input latches the flag.
    a_r7_ext_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_in && !$past(ext_in)) |=> det);

    // R9: a clear without a new edge drops the flag, even with the pin high.
    a_r9_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(ext_in && !$past(ext_in))) |=> !det);

    // R9: a set flag holds without a clear.
    a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (det && !clr) |=> det);
endmodule

// File: rtl/pcc_preset_gen.sv
module pcc_preset_gen #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_req,
    input  logic         ext_det,
    input  logic         ring_en,
    input  logic         coin,
    input  logic [W-1:0] preset_val,
    output logic         stb,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic         or_prev;
        logic         stb;
        logic [W-1:0] value;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    src_any;
    logic    rise;

    always_comb begin
        src_any      = host_req | ext_det | (ring_en & coin);
        rise         = src_any & ~st_q.or_prev;
        st_d.or_prev = src_any;
        st_d.stb     = rise;
        // The preset value is captured together with the strobe.
        st_d.value   = rise ? preset_val : st_q.value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb   = st_q.stb;
    assign value = st_q.value;

    // R5: the load strobe lasts a single cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R5: the value output changes only together with a strobe.
    a_r5_value_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> $stable(value));
endmodule

// File: rtl/preset_coin_ctrl.sv
module preset_coin_ctrl #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] set_val,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             host_preset,
    input  logic             ext_preset,
    input  logic             ring_en,
    input  logic             coin_clr,
    input  logic             ext_clr,
    input  logic             coin_pin_en,
    output logic             load_stb,
    output logic [CNT_W-1:0] load_value,
    output logic             cmp_gt,
    output logic             cmp_eq,
    output logic             cmp_lt,
    output logic             coin_flag,
    output logic             ext_flag,
    output logic             coin_pin
);
    import pcc_pkg::*;

    rel_t rel;

    pcc_compare #(.W(CNT_W)) u_cmp (
        .count  (count),
        .target (set_val),
        .rel    (rel)
    );

    pcc_coin_latch u_coin (
        .clk   (clk),
        .rst_n (rst_n),
        .eq    (rel.eq),
        .clr   (coin_clr),
        .coin  (coin_flag)
    );

    pcc_ext_latch u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_preset),
        .clr    (ext_clr),
        .det    (ext_flag)
    );

    pcc_preset_gen #(.W(CNT_W)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_preset),
        .ext_det    (ext_flag),
        .ring_en    (ring_en),
        .coin       (coin_flag),
        .preset_val (preset_val),
        .stb        (load_stb),
        .value      (load_value)
    );

    assign cmp_gt   = rel.gt;
    assign cmp_eq   = rel.eq;
    assign cmp_lt   = rel.lt;
    assign coin_pin = coin_pin_en & coin_flag;

    // R1: exactly one relation holds.
    a_r1_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cmp_gt, cmp_eq, cmp_lt}) == 1);

    // R2: equality at an edge leaves the flag set after it.
    a_r2_coin_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_eq |=> coin_flag);

    // R8: a detect flag held over two edges blocks every load.
    a_r8_ext_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && $past(ext_flag) && $past(ext_flag, 2)) |-> !load_stb);

    // R10: the ring reload arrives two edges after equality.
    a_r10_ring_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_en && $rose(coin_flag) && !host_preset && !ext_flag
         && !$past(host_preset) && !$past(ext_flag)) |=> load_stb);
endmodule

// File: tb/test_preset_coin_ctrl.sv
module test_preset_coin_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 24;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] count, set_val, preset_val;
    logic         host_preset, ext_preset, ring_en, coin_clr, ext_clr, coin_pin_en;
    logic         load_stb, cmp_gt, cmp_eq, cmp_lt, coin_flag, ext_flag, coin_pin;
    logic [W-1:0] load_value;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    preset_coin_ctrl #(.CNT_W(W)) i_preset_coin_ctrl (
        .clk(clk), .rst_n(rst_n), .count(count), .set_val(set_val),
        .preset_val(preset_val), .host_preset(host_preset), .ext_preset(ext_preset),
        .ring_en(ring_en), .coin_clr(coin_clr), .ext_clr(ext_clr),
        .coin_pin_en(coin_pin_en), .load_stb(load_stb), .load_value(load_value),
        .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .coin_flag(coin_flag),
        .ext_flag(ext_flag), .coin_pin(coin_pin)
    );

    // Reference model, written from the requirements.
    logic         m_coin, m_det, m_eprev, m_orprev, m_stb;
    logic [W-1:0] m_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_coin <= 0; m_det <= 0; m_eprev <= 0; m_orprev <= 0; m_stb <= 0; m_val <= '0;
        end else begin
            m_coin   <= (count == set_val) | (m_coin & ~coin_clr);
            m_det    <= (ext_preset & ~m_eprev) | (m_det & ~ext_clr);
            m_eprev  <= ext_preset;
            m_orprev <= host_preset | m_det | (ring_en & m_coin);
            m_stb    <= (host_preset | m_det | (ring_en & m_coin)) & ~m_orprev;
            if ((host_preset | m_det | (ring_en & m_coin)) & ~m_orprev) m_val <= preset_val;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        host_preset = 0; ext_preset = 0; ring_en = 0; coin_clr = 0; ext_clr = 0;
        coin_pin_en = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; idle_inputs(); count = '0; set_val = '0; preset_val = 24'h000008;
        repeat (3) step();
        rst_n = 1;
        #1;
        chk("R11 strobe after reset", load_stb, 0);
        chk("R11 ext flag after reset", ext_flag, 0);
        chk("R11 coin flag after reset", coin_flag, 0);
        step();
        chk("R11 coin set from zero compare", coin_flag, 1);
        chk("R11 no strobe", load_stb, 0);

        // R1 relation flags
        count = 24'd10; set_val = 24'd3; #1;
        chk("R1 gt", {cmp_gt, cmp_eq, cmp_lt}, 3'b100);
        count = 24'd3; set_val = 24'd10; #1;
        chk("R1 lt", {cmp_gt, cmp_eq, cmp_lt}, 3'b001);
        count = 24'hFFFFFF; set_val = 24'h000000; #1;
        chk("R1 gt at max", {cmp_gt, cmp_eq, cmp_lt}, 3'b100);
        set_val = 24'hFFFFFF; #1;
        chk("R1 eq at max", {cmp_gt, cmp_eq, cmp_lt}, 3'b010);

        // R2 set wins over clear; R3 clear
        coin_clr = 1; step();
        chk("R2 set wins over clear", coin_flag, 1);
        count = 24'd1; step();
        chk("R3 clear when unequal", coin_flag, 0);
        coin_clr = 0;

        // R4 pin gating
        coin_pin_en = 1; #1;
        chk("R4 pin off without flag", coin_pin, 0);
        set_val = 24'd1; step();
        chk("R4 pin on", coin_pin, 1);
        coin_pin_en = 0; #1;
        chk("R4 pin gated off", coin_pin, 0);
        set_val = 24'd50; coin_clr = 1; step(); coin_clr = 0;

        // R5 host preset
        preset_val = 24'h123456; host_preset = 1; step();
        chk("R5 strobe on host rise", load_stb, 1);
        chk("R5 load value", load_value, 24'h123456);
        preset_val = 24'h0; step();
        chk("R5 strobe one cycle", load_stb, 0);
        chk("R5 value held", load_value, 24'h123456);

        // R6 host held, ring coincidence rises: no load
        ring_en = 1; count = 24'd50; step();
        chk("R6 coin set", coin_flag, 1);
        chk("R6 masked", load_stb, 0);
        step();
        chk("R6 still masked", load_stb, 0);
        host_preset = 0; ring_en = 0; count = 24'd7; coin_clr = 1; step(); coin_clr = 0;
        step();

        // R7 external detect and load
        preset_val = 24'h00ABCD; ext_preset = 1; step();
        chk("R7 ext flag set", ext_flag, 1);
        chk("R7 no strobe yet", load_stb, 0);
        step();
        chk("R7 strobe", load_stb, 1);
        chk("R7 value", load_value, 24'h00ABCD);

        // R8 blocking
        host_preset = 1; step();
        chk("R8 host blocked", load_stb, 0);
        step(); host_preset = 0;
        chk("R8 host blocked later", load_stb, 0);
        ext_preset = 0; step(); ext_preset = 1; step();
        chk("R8 new ext edge blocked", load_stb, 0);
        step();
        chk("R8 still blocked", load_stb, 0);

        // R9 clear while pin held
        ext_clr = 1; step(); ext_clr = 0;
        chk("R9 cleared with pin high", ext_flag, 0);
        step();
        chk("R9 held level no redetect", ext_flag, 0);
        chk("R9 no strobe on clear", load_stb, 0);
        ext_preset = 0; step(); ext_preset = 1; step();
        chk("R9 new edge detects", ext_flag, 1);
        step();
        chk("R9 load after new edge", load_stb, 1);
        ext_preset = 0; ext_clr = 1; step(); ext_clr = 0; step();

        // R10 ring reload
        preset_val = 24'd8; ring_en = 1; count = 24'd0; set_val = 24'd0; step();
        chk("R10 coin latched", coin_flag, 1);
        chk("R10 not yet", load_stb, 0);
        step();
        chk("R10 reload two edges after equality", load_stb, 1);
        chk("R10 reload value", load_value, 24'd8);
        count = 24'd8; coin_clr = 1; ring_en = 0; step(); coin_clr = 0;
        count = 24'd0; step(); step();
        chk("R10 no reload with ring off", load_stb, 0);
        coin_clr = 1; count = 24'd3; step(); coin_clr = 0;

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            chk("R5 random strobe", load_stb, m_stb);
            if (m_stb) chk("R5 random value", load_value, m_val);
            chk("R2 random coin", coin_flag, m_coin);
            chk("R7 random ext", ext_flag, m_det);
            if ($urandom % 8 == 0) begin
                count = W'($urandom); set_val = W'($urandom);
            end else begin
                count = W'($urandom % 4); set_val = W'($urandom % 4);
            end
            preset_val = W'($urandom);
            if ($urandom % 6 == 0) host_preset = ~host_preset;
            if ($urandom % 5 == 0) ext_preset = ~ext_preset;
            if ($urandom % 10 == 0) ring_en = ~ring_en;
            coin_clr    = ($urandom % 3 == 0);
            ext_clr     = ($urandom % 6 == 0);
            coin_pin_en = $urandom % 2;
            #1;
            chk("R1 random flags", {cmp_gt, cmp_eq, cmp_lt},
                {count > set_val, count == set_val, count < set_val});
            chk("R4 random pin", coin_pin, coin_pin_en & m_coin);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule